// File: doc/BRIEF.md
# Real-Time Clock Alarm Match Comparator

This block watches the running calendar of a real-time clock and decides when a single programmed alarm has been reached. The current seconds, minutes, hours, day, month and weekday arrive as bytes, together with six alarm bytes. Each alarm byte uses its top bit as a switch that says whether that field takes part in the comparison. The remaining bits hold the target value. On every seconds tick, if the alarm is globally enabled, at least one field is switched on, and every switched-on field equals the clock, a sticky flag is set.

The flag stays set until software pulses a clear strobe. An interrupt request is the flag gated by the global alarm enable. Only the low six bits of the hour byte are compared, because the clock keeps its 24-hour mode bit in bit 7 of its hour register. The weekday is a small binary number and is not BCD. Time keeping, alarm register storage and the host bus are handled elsewhere.

Top module: `alm_match_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `alarm_flag` and `alarm_irq` are 0.
- R2: Bit 7 of each of the six alarm bytes enables comparison of that field (1 = compare). A field whose bit 7 is 0 never blocks a match, whatever its value.
- R3: For seconds, minutes, day and month, bits 6:0 of the clock byte are compared with bits 6:0 of the alarm byte. Bit 7 of either byte has no effect on equality.
- R4: For hours, only bits 5:0 of the clock and alarm bytes are compared. Bits 7:6 of both, including the clock's 24-hour mode bit 7, are ignored.
- R5: For weekday, only bits 2:0 (binary 0 to 6) are compared. Bits 6:3 of both bytes are ignored.
- R6: A match is taken only on a clock edge at which `sec_tick` is 1. The flag reads 1 from the cycle after that edge.
- R7: When no alarm byte has bit 7 set, the flag is never set.
- R8: When `alarm_enable` is 0 at the tick edge, the flag is not set.
- R9: Once set, the flag holds until an edge with `flag_clear` at 1 and no new match. It then reads 0 from the next cycle.
- R10: A match and `flag_clear` on the same edge leave the flag set.
- R11: `alarm_irq` equals `alarm_flag` AND `alarm_enable` in the same cycle. Dropping the enable masks the request without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hour, BCD in bits 5:0, bit 7 is 24-hour mode |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_wday | input | 8 | Current weekday, binary in bits 2:0 |
| alm_sec | input | 8 | Alarm seconds, bit 7 compare enable |
| alm_min | input | 8 | Alarm minutes, bit 7 compare enable |
| alm_hour | input | 8 | Alarm hour, bit 7 compare enable |
| alm_day | input | 8 | Alarm day, bit 7 compare enable |
| alm_mon | input | 8 | Alarm month, bit 7 compare enable |
| alm_wday | input | 8 | Alarm weekday, bit 7 compare enable |
| alarm_enable | input | 1 | Global alarm enable |
| flag_clear | input | 1 | Clear strobe for the sticky flag |
| alarm_flag | output | 1 | Sticky alarm match flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is stable around the clock edge and known after reset. The flag properties also assume that the clock presents legal field values, so that a tick is a well-defined event. Beyond that, they make no assumption about how often `sec_tick` or `flag_clear` pulse. The stimulus changes inputs only on falling edges. Its random part draws legal BCD values for every field and copies the clock into the alarm most of the time so that matches are frequent. It then flips the spare bits (hour bits 7:6, weekday bits 6:3) to exercise the masking.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int EN_BIT     = FIELD_W - 1;
    localparam int STAMP_W    = NUM_FIELDS * FIELD_W;

    typedef logic [FIELD_W-1:0] byte_t;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DAY  = 3'd3,
        F_MON  = 3'd4,
        F_WDAY = 3'd5
    } field_e;

    // Fields packed with seconds in the least significant byte.
    typedef struct packed {
        byte_t wday;
        byte_t mon;
        byte_t day;
        byte_t hour;
        byte_t min;
        byte_t sec;
    } stamp_t;

    typedef struct packed {
        logic en;
        logic eq;
    } cmp_t;

    // Bits of a field that carry its value; enable and mode bits drop out.
    function automatic byte_t value_mask(field_e f);
        case (f)
            F_HOUR:  return byte_t'(8'h3F);
            F_WDAY:  return byte_t'(8'h07);
            default: return byte_t'(8'h7F);
        endcase
    endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
    import alm_pkg::*;
#(
    parameter field_e KIND = F_SEC
) (
    input  byte_t now_b,
    input  byte_t alm_b,
    output cmp_t  res
);
    localparam byte_t MASK = value_mask(KIND);

    always_comb begin
        res.en = alm_b[EN_BIT];
        res.eq = ((now_b ^ alm_b) & MASK) == '0;
    end
endmodule

// File: rtl/alm_match_eval.sv
module alm_match_eval
    import alm_pkg::*;
(
    input  stamp_t now_s,
    input  stamp_t alm_s,
    input  logic   tick,
    input  logic   alm_en,
    output logic   hit
);
    logic [STAMP_W-1:0]    now_v;
    logic [STAMP_W-1:0]    alm_v;
    logic [NUM_FIELDS-1:0] en_v;
    logic [NUM_FIELDS-1:0] eq_v;

    assign now_v = now_s;
    assign alm_v = alm_s;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        cmp_t r;
        alm_field_cmp #(.KIND(field_e'(i))) u_cmp (
            .now_b (now_v[i*FIELD_W +: FIELD_W]),
            .alm_b (alm_v[i*FIELD_W +: FIELD_W]),
            .res   (r)
        );
        assign en_v[i] = r.en;
        assign eq_v[i] = r.eq;
    end

    logic any_en;
    logic all_ok;

    always_comb begin
        any_en = |en_v;
        all_ok = &(~en_v | eq_v);
        hit    = tick && alm_en && any_en && all_ok;
    end
endmodule

// File: rtl/alm_flag_reg.sv
module alm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag));
endmodule

// File: rtl/alm_match_top.sv
module alm_match_top
    import alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_mon,
    input  logic [7:0] cur_wday,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_day,
    input  logic [7:0] alm_mon,
    input  logic [7:0] alm_wday,
    input  logic       alarm_enable,
    input  logic       flag_clear,
    output logic       alarm_flag,
    output logic       alarm_irq
);
    stamp_t now_s;
    stamp_t alm_s;
    logic   hit;

    always_comb begin
        now_s = '{wday: cur_wday, mon: cur_mon, day: cur_day,
                  hour: cur_hour, min: cur_min, sec: cur_sec};
        alm_s = '{wday: alm_wday, mon: alm_mon, day: alm_day,
                  hour: alm_hour, min: alm_min, sec: alm_sec};
    end

    alm_match_eval u_eval (
        .now_s  (now_s),
        .alm_s  (alm_s),
        .tick   (sec_tick),
        .alm_en (alarm_enable),
        .hit    (hit)
    );

    alm_flag_reg u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit),
        .clr_i (flag_clear),
        .flag  (alarm_flag)
    );

    assign alarm_irq = alarm_flag && alarm_enable;

    logic no_field_on;
    assign no_field_on = !(alm_sec[7] || alm_min[7] || alm_hour[7] ||
                           alm_day[7] || alm_mon[7] || alm_wday[7]);

    a_r6_no_tick_no_set: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !alarm_flag) |=> !alarm_flag);
    a_r8_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        (!alarm_enable && !alarm_flag) |=> !alarm_flag);
    a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
        (no_field_on && !alarm_flag) |=> !alarm_flag);
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (alarm_flag && alarm_enable));
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!alarm_flag && !alarm_irq));
endmodule

// File: tb/alm_match_top_test.sv
`timescale 1ns/1ps
module alm_match_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic en = 1'b0;
    logic clr = 1'b0;
    logic [7:0] nw [6];
    logic [7:0] al [6];
    logic flag;
    logic irq;

    int checks = 0;
    int fails = 0;
    logic exp_flag = 1'b0;

    always #10 clk = ~clk;

    alm_match_top uut (
        .clk(clk), .rst(rst), .sec_tick(tick),
        .cur_sec(nw[0]), .cur_min(nw[1]), .cur_hour(nw[2]),
        .cur_day(nw[3]), .cur_mon(nw[4]), .cur_wday(nw[5]),
        .alm_sec(al[0]), .alm_min(al[1]), .alm_hour(al[2]),
        .alm_day(al[3]), .alm_mon(al[4]), .alm_wday(al[5]),
        .alarm_enable(en), .flag_clear(clr),
        .alarm_flag(flag), .alarm_irq(irq)
    );

    function automatic logic [7:0] fmask(int i);
        if (i == 2) return 8'h3F;
        if (i == 5) return 8'h07;
        return 8'h7F;
    endfunction

    function automatic logic model_hit();
        logic any = 1'b0;
        logic ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (al[i][7]) begin
                any = 1'b1;
                if ((nw[i] & fmask(i)) != (al[i] & fmask(i))) ok = 1'b0;
            end
        end
        return tick && en && any && ok;
    endfunction

    function automatic logic [7:0] rand_bcd(int lo, int hi);
        int v = lo + int'($urandom % (hi - lo + 1));
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Inputs are set between negedges; one posedge passes inside this task.
    task automatic step(string req);
        if (model_hit()) exp_flag = 1'b1;
        else if (clr)    exp_flag = 1'b0;
        @(negedge clk);
        check(req, flag, exp_flag);
        check(req, irq, exp_flag && en);
    endtask

    task automatic base_time();
        nw[0] = 8'h45; nw[1] = 8'h30; nw[2] = 8'h93;
        nw[3] = 8'h21; nw[4] = 8'h07; nw[5] = 8'h03;
        al[0] = 8'hC5; al[1] = 8'hB0; al[2] = 8'h93;
        al[3] = 8'hA1; al[4] = 8'h87; al[5] = 8'h83;
        tick = 1'b1; en = 1'b1; clr = 1'b0;
    endtask

    task automatic do_clear();
        tick = 1'b0; clr = 1'b1;
        step("R9");
        clr = 1'b0;
    endtask

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 6; i++) begin nw[i] = '0; al[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1", flag, 1'b0);
        check("R1", irq, 1'b0);
        rst = 1'b0;
        step("R1");

        // R2/R6: all fields enabled and equal
        base_time();
        step("R2 full match");
        tick = 1'b0;
        step("R9 sticky");
        step("R9 sticky");
        do_clear();

        // R6: match but no tick
        base_time(); tick = 1'b0;
        step("R6 no tick");
        // R8: alarm disabled
        base_time(); en = 1'b0;
        step("R8 disabled");
        // R7: no field enabled
        base_time();
        for (int i = 0; i < 6; i++) al[i][7] = 1'b0;
        step("R7 all off");

        // R2: only seconds enabled, other fields differ
        base_time();
        for (int i = 1; i < 6; i++) al[i] = 8'h00;
        step("R2 seconds only");
        do_clear();
        base_time(); al[0] = 8'hC6;
        step("R3 seconds differ");

        // R3: bit 7 of clock seconds ignored
        base_time(); nw[0] = 8'hC5;
        step("R3 bit7 ignored");
        do_clear();

        // R4: hour bits 7:6 ignored, real hour mismatch blocks
        base_time(); nw[2] = 8'h93; al[2] = 8'hD3;
        step("R4 hour mode bits");
        do_clear();
        base_time(); al[2] = 8'h94;
        step("R4 hour differ");

        // R5: weekday high bits ignored, value mismatch blocks
        base_time(); nw[5] = 8'h7B; al[5] = 8'hF3;
        step("R5 weekday spare bits");
        do_clear();
        base_time(); al[5] = 8'h84;
        step("R5 weekday differ");

        // R10: set and clear on the same edge
        base_time(); clr = 1'b1;
        step("R10 set beats clear");
        // R11: enable low masks irq, flag held
        tick = 1'b0; clr = 1'b0; en = 1'b0;
        step("R11 masked irq");
        check("R11", flag, 1'b1);
        en = 1'b1;
        step("R11 irq back");
        do_clear();

        // Random phase
        for (int n = 0; n < 600; n++) begin
            nw[0] = rand_bcd(0, 59);
            nw[1] = rand_bcd(0, 59);
            nw[2] = rand_bcd(0, 23) | 8'({$urandom % 4, 6'b0});
            nw[3] = rand_bcd(1, 31);
            nw[4] = rand_bcd(1, 12);
            nw[5] = 8'({$urandom % 16, 3'(($urandom % 7))});
            for (int i = 0; i < 6; i++) begin
                if (($urandom % 8) != 0) al[i] = nw[i] & 8'h7F;
                else if (i == 2) al[i] = rand_bcd(0, 23);
                else al[i] = rand_bcd(0, 59);
                if (i == 2) al[i][6] = 1'($urandom % 2);
                al[i][7] = 1'(($urandom % 3) != 0);
            end
            tick = 1'(($urandom % 4) != 0);
            en   = 1'(($urandom % 5) != 0);
            clr  = 1'(($urandom % 5) == 0);
            step("R2 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule